// File: doc/BRIEF.md
# ADC Conversion Control and Result Logic

This block is the digital side of an analog-to-digital converter. Conversions are started in one of two ways, chosen by a configuration bit. A write to the first control register starts one. The other source is a rising edge on a hardware trigger pin. A status bit shows whether a conversion is running. The converter itself sits outside the block. The block gives it a one-cycle start pulse and takes back a done pulse together with a 12-bit raw code.

Each completed code is brought down to the selected resolution (12, 10 or 8 bits). It can then be tested against a programmed compare value:

- When compare is off, every completion is stored.
- When compare is on, only results that meet the chosen condition are stored. The stored value is then the difference from the compare value, not the raw code.

Results are read as a high byte and a low byte. In the 10- and 12-bit modes, reading the high byte holds the pair until the low byte is read, so that both bytes come from the same conversion. Software uses a simple byte-wide read/write port.

Top module: `adc_ctrl`

## Requirements
- R1: With the start source bit (CTL2 bit 6) at 0, a write to CTL1 (address 0) starts a conversion. One cycle after the write, `conv_start` is high for one cycle and the active flag is set.
- R2: With the start source bit at 1, a rising edge on `hw_trig` while idle starts a conversion one cycle later. In this mode a CTL1 write starts nothing. With the start source bit at 0, `hw_trig` is ignored.
- R3: The active flag is CTL2 bit 7. It clears on the cycle after an accepted `conv_done`. It is read-only, and writes to it are ignored.
- R4: A CTL1 write while a conversion is active aborts it: `conv_abort` pulses and no result is stored. In hardware start mode the active flag clears. In software start mode the same write starts a new conversion.
- R5: The compare enable bit is CTL2 bit 5 and the condition bit is CTL2 bit 4. When the condition bit is 1, a result is stored if the aligned result is greater than or equal to the compare value. When it is 0, a result is stored if the aligned result is strictly less. A failed compare leaves the result registers unchanged.
- R6: When compare is enabled and passes, the stored value is (aligned result minus compare value) modulo 2^width, where width is the active resolution.
- R7: In 10- and 12-bit modes, a read of RES_HI (address 2) blocks new results until RES_LO (address 3) is read. A completion that arrives while blocked is discarded.
- R8: In 8-bit mode, reading RES_HI does not block later results.
- R9: Resolution is set by CTL1 bits 1:0: 0 selects 8-bit, 1 selects 10-bit, and 2 or 3 select 12-bit. In 10-bit mode the code is raw[11:2]; in 8-bit mode it is raw[11:4]. The compare uses the same number of low bits of the compare register (CMP_HI at address 4, low nibble; CMP_LO at address 5). Unused high result bits read as zero.
- R10: CTL2 (address 1) resets to 0. Bits 3:0 always read as zero, and only bits 6:4 are writable.
- R11: If `conv_done` arrives in the same cycle as a CTL1 write, the completion is discarded and the write's effect (abort, and restart in software mode) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (has side effects on RES_HI and RES_LO) |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| hw_trig | input | 1 | Hardware start request, acts on its rising edge |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_abort | output | 1 | One-cycle pulse when a running conversion is killed |
| conv_done | input | 1 | Converter completion pulse |
| conv_code | input | 12 | Raw converter code, valid together with `conv_done` |

## Verification
The tightest case is a converter completion that lands in the same cycle as a CTL1 write, which both aborts and restarts the conversion. The bench provokes it by raising `conv_done` with a distinct code in the exact cycle that it drives the write. It judges the outcome in three ways:

- the result bytes must still hold the earlier value;
- a new start pulse and an abort pulse must both appear, and the active flag must read set;
- the next ordinary completion must be stored normally.

// File: rtl/adc_ctrl_pkg.sv
// Shared types and constants for the ADC control block.
// Assumes a 3-bit register address space and the fixed 12/10/8-bit
// resolution ladder (the lower modes drop 2 or 4 LSBs of the raw code).
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        RES_8   = 2'd0,
        RES_10  = 2'd1,
        RES_12  = 2'd2,
        RES_12B = 2'd3
    } res_mode_e;

    localparam int unsigned A_CTL1   = 0;
    localparam int unsigned A_CTL2   = 1;
    localparam int unsigned A_RES_HI = 2;
    localparam int unsigned A_RES_LO = 3;
    localparam int unsigned A_CMP_HI = 4;
    localparam int unsigned A_CMP_LO = 5;

    localparam logic [2:0] DROP_10 = 3'd2;
    localparam logic [2:0] DROP_8  = 3'd4;

    // Number of raw LSBs discarded in a given resolution mode.
    function automatic logic [2:0] drop_bits(res_mode_e m);
        case (m)
            RES_8:   return DROP_8;
            RES_10:  return DROP_10;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_ctl.sv
// Start/abort sequencer for the ADC control block.
// Decides when a conversion begins (software write or hardware edge),
// keeps the active flag, and flags which completions are accepted.
// Assumes the converter restarts on every start pulse and drops any
// conversion that was aborted.
module adc_trig_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl1_wr,
    input  logic trig_hw,
    input  logic hw_trig,
    input  logic conv_done,
    output logic active,
    output logic conv_start,
    output logic conv_abort,
    output logic done_ok
);
    logic hw_q;
    logic hw_rise;
    logic sw_go;
    logic hw_go;
    logic kill;

    // Decode start, kill and accepted completion for this cycle.
    always_comb begin
        hw_rise = hw_trig && !hw_q;
        sw_go   = ctl1_wr && !trig_hw;
        hw_go   = trig_hw && hw_rise && !active;
        kill    = ctl1_wr && active;
        done_ok = conv_done && active && !ctl1_wr;
    end

    // Register the trigger history, the active flag and the converter strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q       <= 1'b0;
            active     <= 1'b0;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
        end else begin
            hw_q       <= hw_trig;
            conv_start <= sw_go || hw_go;
            conv_abort <= kill;
            if (sw_go || hw_go)
                active <= 1'b1;
            else if (kill || done_ok)
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_cmp_unit.sv
// Result shaping for the ADC control block.
// Aligns the raw code to the active resolution and runs the optional
// threshold compare. Produces the value to store and a keep flag.
// Purely combinational; assumes the raw code is right-justified in CODE_W.
module adc_cmp_unit
    import adc_ctrl_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  res_mode_e          mode,
    input  logic [CODE_W-1:0]  raw,
    input  logic [CODE_W-1:0]  cmp_val,
    input  logic               cmp_en,
    input  logic               cmp_ge,
    output logic               keep,
    output logic [CODE_W-1:0]  value
);
    logic [2:0]        drop;
    logic [CODE_W-1:0] mask;
    logic [CODE_W-1:0] aligned;
    logic [CODE_W-1:0] ref_v;
    logic [CODE_W-1:0] diff;
    logic              hit;

    // Align the code, test the threshold and form the stored value.
    always_comb begin
        drop    = drop_bits(mode);
        mask    = {CODE_W{1'b1}} >> drop;
        aligned = raw >> drop;
        ref_v   = cmp_val & mask;
        hit     = cmp_ge ? (aligned >= ref_v) : (aligned < ref_v);
        diff    = (aligned + (~ref_v) + CODE_W'(1)) & mask;
        keep    = !cmp_en || hit;
        value   = cmp_en ? diff : aligned;
    end
endmodule

// File: rtl/adc_result_reg.sv
// Result holding register with a high/low read interlock.
// In 10/12-bit modes a high-byte read freezes the value until the low
// byte is read; in 8-bit mode the interlock is bypassed.
// Assumes high and low reads never fall in the same cycle (one address).
module adc_result_reg
    import adc_ctrl_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  res_mode_e          mode,
    input  logic               store_req,
    input  logic               keep,
    input  logic [CODE_W-1:0]  value,
    input  logic               hi_rd,
    input  logic               lo_rd,
    output logic [CODE_W-1:0]  res_q,
    output logic               lock_q
);
    logic lock_on;
    logic blocked;

    // Work out whether a completion may be written this cycle.
    always_comb begin
        lock_on = (mode != RES_8);
        blocked = lock_on && ((lock_q && !lo_rd) || hi_rd);
    end

    // Capture accepted results and track the interlock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            if (store_req && keep && !blocked)
                res_q <= value;
            if (lo_rd)
                lock_q <= 1'b0;
            else if (hi_rd && lock_on)
                lock_q <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_ctrl.sv
// Top of the ADC conversion control and result logic.
// Holds the software registers, decodes the byte bus and ties together
// the sequencer, the compare unit and the result register.
// Assumes a converter that pulses conv_done with conv_code valid.
module adc_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hw_trig,
    output logic              conv_start,
    output logic              conv_abort,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code
);
    localparam int HI_W = CODE_W - DATA_W;

    res_mode_e         mode_q;
    logic              trig_hw_q;
    logic              cmp_en_q;
    logic              cmp_ge_q;
    logic [CODE_W-1:0] cmp_q;
    logic              active;
    logic              done_ok;
    logic              keep;
    logic [CODE_W-1:0] value;
    logic [CODE_W-1:0] res_q;
    logic              lock_q;
    logic [CODE_W-1:0] res_m;
    logic              ctl1_wr;
    logic              hi_rd;
    logic              lo_rd;

    // Decode the bus strobes that have side effects.
    always_comb begin
        ctl1_wr = bus_wr && (bus_addr == ADDR_W'(A_CTL1));
        hi_rd   = bus_rd && (bus_addr == ADDR_W'(A_RES_HI));
        lo_rd   = bus_rd && (bus_addr == ADDR_W'(A_RES_LO));
    end

    // Software configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= RES_8;
            trig_hw_q <= 1'b0;
            cmp_en_q  <= 1'b0;
            cmp_ge_q  <= 1'b0;
            cmp_q     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(A_CTL1): mode_q <= res_mode_e'(bus_wdata[1:0]);
                ADDR_W'(A_CTL2): begin
                    trig_hw_q <= bus_wdata[6];
                    cmp_en_q  <= bus_wdata[5];
                    cmp_ge_q  <= bus_wdata[4];
                end
                ADDR_W'(A_CMP_HI): cmp_q[CODE_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
                ADDR_W'(A_CMP_LO): cmp_q[DATA_W-1:0]      <= bus_wdata;
                default: ;
            endcase
        end
    end

    adc_trig_ctl u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl1_wr    (ctl1_wr),
        .trig_hw    (trig_hw_q),
        .hw_trig    (hw_trig),
        .conv_done  (conv_done),
        .active     (active),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .done_ok    (done_ok)
    );

    adc_cmp_unit #(.CODE_W(CODE_W)) u_cmp (
        .mode    (mode_q),
        .raw     (conv_code),
        .cmp_val (cmp_q),
        .cmp_en  (cmp_en_q),
        .cmp_ge  (cmp_ge_q),
        .keep    (keep),
        .value   (value)
    );

    adc_result_reg #(.CODE_W(CODE_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .store_req (done_ok),
        .keep      (keep),
        .value     (value),
        .hi_rd     (hi_rd),
        .lo_rd     (lo_rd),
        .res_q     (res_q),
        .lock_q    (lock_q)
    );

    // Read multiplexer with result bits above the active width forced low.
    always_comb begin
        res_m = res_q & ({CODE_W{1'b1}} >> drop_bits(mode_q));
        case (bus_addr)
            ADDR_W'(A_CTL1):   bus_rdata = DATA_W'(mode_q);
            ADDR_W'(A_CTL2):   bus_rdata = {active, trig_hw_q, cmp_en_q, cmp_ge_q, 4'b0000};
            ADDR_W'(A_RES_HI): bus_rdata = DATA_W'(res_m[CODE_W-1:DATA_W]);
            ADDR_W'(A_RES_LO): bus_rdata = res_m[DATA_W-1:0];
            ADDR_W'(A_CMP_HI): bus_rdata = DATA_W'(cmp_q[CODE_W-1:DATA_W]);
            ADDR_W'(A_CMP_LO): bus_rdata = cmp_q[DATA_W-1:0];
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_ctrl_chk.sv
// Protocol checker for adc_ctrl, attached by bind.
// Observes the bus, the converter handshake and the result register.
module adc_ctrl_chk
    import adc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl1_wr,
    input logic              conv_start,
    input logic              conv_abort,
    input logic              conv_done,
    input logic              active,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input res_mode_e         mode_q,
    input logic              lock_q,
    input logic              lo_rd,
    input logic [CODE_W-1:0] res_q
);
    assert_start_sets_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> active);

    assert_done_clears_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && active && !ctl1_wr) |=> !active);

    assert_abort_idles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_abort && !conv_start) |-> !active);

    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && mode_q != RES_8 && !lo_rd) |=> $stable(res_q));

    assert_hi_zero_8bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_RES_HI) && mode_q == RES_8) |-> bus_rdata == '0);

    assert_ctl2_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_CTL2)) |-> bus_rdata[3:0] == 4'b0000);
endmodule

bind adc_ctrl adc_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl1_wr    (ctl1_wr),
    .conv_start (conv_start),
    .conv_abort (conv_abort),
    .conv_done  (conv_done),
    .active     (active),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .mode_q     (mode_q),
    .lock_q     (lock_q),
    .lo_rd      (lo_rd),
    .res_q      (res_q)
);

// File: tb/adc_ctrl_bench.sv
module adc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        hw_trig = 1'b0;
    logic        conv_start;
    logic        conv_abort;
    logic        conv_done = 1'b0;
    logic [11:0] conv_code = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_ctrl u_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .hw_trig(hw_trig), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_done(conv_done), .conv_code(conv_code)
    );

    // mode, cmp_en, cmp_ge, cmp value, raw code, expected RES_HI, RES_LO
    // Rows 4..10 exercise R5 (compare pass/fail) and R6 (difference).
    localparam int NV = 10;
    localparam logic [43:0] VEC [NV] = '{
        {2'd2, 1'b0, 1'b0, 12'h000, 12'hABC, 8'h0A, 8'hBC},
        {2'd1, 1'b0, 1'b0, 12'h000, 12'hABC, 8'h02, 8'hAF},
        {2'd0, 1'b0, 1'b0, 12'h000, 12'hABC, 8'h00, 8'hAB},
        {2'd2, 1'b1, 1'b1, 12'h100, 12'h345, 8'h02, 8'h45},
        {2'd2, 1'b1, 1'b1, 12'h400, 12'h345, 8'h02, 8'h45},
        {2'd2, 1'b1, 1'b0, 12'h400, 12'h345, 8'h0F, 8'h45},
        {2'd2, 1'b1, 1'b0, 12'h345, 12'h345, 8'h0F, 8'h45},
        {2'd2, 1'b1, 1'b1, 12'h345, 12'h345, 8'h00, 8'h00},
        {2'd0, 1'b1, 1'b0, 12'h0F0, 12'h123, 8'h00, 8'h22},
        {2'd1, 1'b1, 1'b1, 12'hC05, 12'h030, 8'h00, 8'h07}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_conv(input logic [11:0] code);
        @(negedge clk);
        conv_done = 1'b1; conv_code = code;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R10)
        rd(3'd1, d); check("R10 ctl2 reset", d, 8'h00);
        rd(3'd2, d); check("R10 res_hi reset", d, 8'h00);
        rd(3'd3, d); check("R10 res_lo reset", d, 8'h00);
        check("R1 conv_start idle", {7'b0, conv_start}, 8'h00);

        // R10 / R3: only bits 6:4 writable, active bit read-only
        wr(3'd1, 8'h8C); rd(3'd1, d); check("R10 ro bits", d, 8'h00);
        wr(3'd1, 8'h70); rd(3'd1, d); check("R10 rw bits", d, 8'h70);
        wr(3'd1, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            string tag;
            v = VEC[i];
            tag = v[41] ? $sformatf("R6 vec%0d", i) : $sformatf("R9 vec%0d", i);
            wr(3'd4, {4'b0, v[39:36]});
            wr(3'd5, v[35:28]);
            wr(3'd1, {2'b00, v[41], v[40], 4'b0});
            wr(3'd0, {6'b0, v[43:42]});
            finish_conv(v[27:16]);
            rd(3'd2, d); check({tag, " hi"}, d, v[15:8]);
            rd(3'd3, d); check({tag, " lo"}, d, v[7:0]);
        end

        // R1 / R3: software start, active flag set and cleared
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h02);
        check("R1 start pulse", {7'b0, conv_start}, 8'h01);
        rd(3'd1, d); check("R1 active set", d, 8'h80);
        check("R1 start one cycle", {7'b0, conv_start}, 8'h00);
        finish_conv(12'h123);
        rd(3'd1, d); check("R3 active cleared", d, 8'h00);
        rd(3'd2, d); check("R3 res_hi", d, 8'h01);
        rd(3'd3, d); check("R3 res_lo", d, 8'h23);

        // R2: hardware start mode
        wr(3'd1, 8'h40);
        wr(3'd0, 8'h02);
        check("R2 no sw start in hw mode", {7'b0, conv_start}, 8'h00);
        rd(3'd1, d); check("R2 idle after write", d, 8'h40);
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); check("R2 hw start", {7'b0, conv_start}, 8'h01);
        hw_trig = 1'b0;
        rd(3'd1, d); check("R2 active via hw", d, 8'hC0);

        // R4: abort in hw mode, late completion discarded
        wr(3'd0, 8'h02);
        check("R4 abort pulse", {7'b0, conv_abort}, 8'h01);
        rd(3'd1, d); check("R4 active cleared", d, 8'h40);
        finish_conv(12'hFFF);
        rd(3'd2, d); check("R4 res_hi kept", d, 8'h01);
        rd(3'd3, d); check("R4 res_lo kept", d, 8'h23);

        // R2: hw_trig ignored in software mode
        wr(3'd1, 8'h00);
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); check("R2 hw ignored", {7'b0, conv_start}, 8'h00);
        hw_trig = 1'b0;
        rd(3'd1, d); check("R2 stays idle", d, 8'h00);

        // R11: completion in the same cycle as a CTL1 write
        wr(3'd0, 8'h02);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h02; bus_wr = 1'b1;
        conv_done = 1'b1; conv_code = 12'h777;
        @(negedge clk);
        bus_wr = 1'b0; conv_done = 1'b0;
        check("R11 restart pulse", {7'b0, conv_start}, 8'h01);
        check("R11 abort pulse", {7'b0, conv_abort}, 8'h01);
        rd(3'd1, d); check("R11 active", d, 8'h80);
        rd(3'd2, d); check("R11 res_hi kept", d, 8'h01);
        rd(3'd3, d); check("R11 res_lo kept", d, 8'h23);
        finish_conv(12'h456);
        rd(3'd2, d); check("R11 next hi", d, 8'h04);
        rd(3'd3, d); check("R11 next lo", d, 8'h56);

        // R7: interlock in 12-bit mode
        rd(3'd2, d); check("R7 hi before", d, 8'h04);
        wr(3'd0, 8'h02);
        finish_conv(12'h9AB);
        rd(3'd3, d); check("R7 lo held", d, 8'h56);
        wr(3'd0, 8'h02);
        finish_conv(12'h9AB);
        rd(3'd2, d); check("R7 hi after release", d, 8'h09);
        rd(3'd3, d); check("R7 lo after release", d, 8'hAB);

        // R8: no interlock in 8-bit mode
        wr(3'd0, 8'h00);
        rd(3'd2, d); check("R8 hi zero", d, 8'h00);
        finish_conv(12'hCDE);
        rd(3'd3, d); check("R8 lo updated", d, 8'hCD);

        finished = 1;
        summary();
    end
endmodule